// File: doc/BRIEF.md
# Audio-to-Carrier Interpolating Amplitude Modulator

This block turns a slow stream of signed audio samples into a double-sideband, full-carrier AM waveform at the converter clock rate. An audio word is captured whenever its strobe is high. The captured value then passes through four rate-raising stages, which raise the rate by ten, then eight, then eight, then eight, for an overall factor of 5120. At a 125 MHz clock, an input near 24.4 kHz becomes one sample per clock.

Each stage holds its input for as many output slots as its factor and smooths the steps with a four-tap moving average. The average divides by four with an arithmetic shift, so a constant input passes through unchanged. A phase-accumulating synthesiser produces a 1 MHz carrier from a quarter-wave sine table. The smoothed message m then scales that carrier by the envelope E = 1 + k·m. The index k is set by an input word, and E is clamped to the range [0, 2). When the enable input is low, the envelope is forced to exactly one, so the pure carrier is sent out.

Top module: `am_interp_mod`

## Requirements
- R1: While `rst_n` is low, `dac_o` is 0, including when reset is asserted in the middle of operation.
- R2: `audio_i` is taken only in a cycle where `audio_vld_i` is high. A change of `audio_i` without the strobe leaves the output envelope unchanged.
- R3: After settling, the envelope is E = 32768 + floor(k·m / 2^15), and `dac_o` = floor(c·E / 2^15). Here k is `mod_idx_i` read as unsigned Q1.15, m is the captured sample read as signed Q0.15, and c is the carrier. The cascade has exactly unity gain for a constant input.
- R4: The carrier phase advances by 34359738 per clock out of 2^32, giving 1 MHz at 125 MHz: 100 rising zero crossings (±1) in 12500 cycles.
- R5: With `en_i` low, `dac_o` is the bare carrier, with a peak magnitude of about 16383 whatever the index and sample are.
- R6: An envelope above 65535 is held at 65535, so the output peak never exceeds 2·16383.
- R7: An envelope below zero is held at zero, and an envelope of zero gives a `dac_o` of 0.
- R8: The first stage updates exactly once every 512 clocks. The later stages update every 64 clocks, every 8 clocks and every clock.
- R9: A new captured sample is fully reflected in the output envelope within 2400 clocks of its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-rate clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| audio_i | input | 16 | Signed audio sample, Q0.15 |
| audio_vld_i | input | 1 | Capture strobe for `audio_i` |
| mod_idx_i | input | 16 | Modulation index k, unsigned Q1.15 |
| en_i | input | 1 | High: modulate. Low: send the bare carrier |
| dac_o | output | 16 | Signed modulated sample, one per clock |

## Verification
Reset acts on `dac_o` at once, so it is checked during reset rather than at a clock edge. A change on `en_i` or `mod_idx_i` reaches `dac_o` two edges later, through the envelope register and then the output register. A new audio value needs up to four first-stage periods of 512 clocks, plus a few periods of the faster stages, before it is fully reflected. The bench therefore waits 2400 clocks after each stimulus before measuring anything. It then takes the peak, trough and rising zero crossings over a window of two or more carrier periods, and compares them with envelope values computed from the formula in R3.

// File: rtl/am_pkg.sv
package am_pkg;

  localparam int NUM_STAGES = 4;

  // Quarter-wave sine sample at the centre of bin idx, using a rational
  // approximation that needs only integer arithmetic at elaboration.
  function automatic int quarter_sine(int idx, int size, int amp);
    longint a;
    longint d;
    longint p;
    longint num;
    longint den;
    a   = 2 * longint'(idx) + 1;
    d   = 4 * longint'(size);
    p   = a * (d - a);
    num = 16 * p * longint'(amp);
    den = 5 * d * d - 4 * p;
    return int'(num / den);
  endfunction

  // Clocks between updates of the first stage: product of all later factors.
  function automatic int rate_span(logic [63:0] factors, int num);
    int prod;
    prod = 1;
    for (int s = 1; s < num; s++) begin
      prod = prod * int'(factors[8*s +: 8]);
    end
    return prod;
  endfunction

endpackage

// File: rtl/am_rate_timebase.sv
module am_rate_timebase #(
  parameter int                NUM     = 4,
  parameter logic [NUM*8-1:0]  FACTORS = {8'd8, 8'd8, 8'd8, 8'd10}
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [NUM-1:0] tick_o
);

  logic [NUM-1:1] wrap;

  assign tick_o[NUM-1] = 1'b1;

  for (genvar s = 0; s < NUM - 1; s++) begin : g_tick
    assign tick_o[s] = &wrap[NUM-1:s+1];
  end

  for (genvar s = 1; s < NUM; s++) begin : g_cnt
    localparam logic [7:0] F = FACTORS[8*s +: 8];
    logic [7:0] cnt_q;
    logic [7:0] cnt_d;

    assign wrap[s] = (cnt_q == F - 8'd1);

    always_comb begin
      cnt_d = cnt_q;
      if (tick_o[s]) begin
        cnt_d = wrap[s] ? 8'd0 : cnt_q + 8'd1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= 8'd0;
      end else begin
        cnt_q <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/am_interp_stage.sv
module am_interp_stage #(
  parameter int W    = 16,
  parameter int TAPS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);

  localparam int SHIFT = $clog2(TAPS);
  localparam int SW    = W + SHIFT;

  logic signed [W-1:0]  hist_q [TAPS-1];
  logic signed [W-1:0]  hist_d [TAPS-1];
  logic signed [SW-1:0] sum;
  logic signed [W-1:0]  out_q;
  logic signed [W-1:0]  out_d;

  always_comb begin
    sum = SW'(din);
    for (int i = 0; i < TAPS - 1; i++) begin
      sum = sum + SW'(hist_q[i]);
    end
    out_d     = W'(sum >>> SHIFT);
    hist_d[0] = din;
    for (int i = 1; i < TAPS - 1; i++) begin
      hist_d[i] = hist_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS - 1; i++) begin
        hist_q[i] <= '0;
      end
      out_q <= '0;
    end else if (tick_i) begin
      hist_q <= hist_d;
      out_q  <= out_d;
    end
  end

  assign dout = out_q;

endmodule

// File: rtl/am_dds.sv
module am_dds
  import am_pkg::*;
#(
  parameter int                   PHASE_W = 32,
  parameter logic [PHASE_W-1:0]   TUNE    = 32'd34359738,
  parameter int                   AW      = 6,
  parameter int                   W       = 16,
  parameter int                   AMP     = 16383
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic signed [W-1:0] car_o
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0]        rom [DEPTH];
  logic [PHASE_W-1:0]  phase_q;
  logic [PHASE_W-1:0]  phase_d;
  logic [1:0]          quad;
  logic [AW-1:0]       idx;
  logic [AW-1:0]       addr;
  logic signed [W-1:0] mag;
  logic signed [W-1:0] car_d;
  logic signed [W-1:0] car_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = W'(quarter_sine(i, DEPTH, AMP));
  end

  always_comb begin
    phase_d = phase_q + TUNE;
    quad    = phase_q[PHASE_W-1 -: 2];
    idx     = phase_q[PHASE_W-3 -: AW];
    addr    = quad[0] ? ~idx : idx;
    mag     = $signed(rom[addr]);
    car_d   = quad[1] ? -mag : mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      car_q   <= '0;
    end else begin
      phase_q <= phase_d;
      car_q   <= car_d;
    end
  end

  assign car_o = car_q;

endmodule

// File: rtl/am_modulator.sv
module am_modulator #(
  parameter int W  = 16,
  parameter int IW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] msg_i,
  input  logic [IW-1:0]       idx_i,
  input  logic                en_i,
  input  logic signed [W-1:0] car_i,
  output logic [IW-1:0]       env_o,
  output logic signed [W-1:0] dac_o
);

  localparam int F   = IW - 1;
  localparam int KMW = W + IW + 1;
  localparam int SW  = KMW + 1;
  localparam int PW  = W + IW + 1;
  localparam logic signed [SW-1:0] ONE_S   = SW'(1) <<< F;
  localparam logic signed [SW-1:0] ENV_MAX = (SW'(1) <<< IW) - SW'(1);
  localparam logic [IW-1:0]        ONE_U   = IW'(1) << F;

  logic signed [KMW-1:0] km;
  logic signed [SW-1:0]  env_sum;
  logic [IW-1:0]         env_d;
  logic [IW-1:0]         env_q;
  logic signed [PW-1:0]  prod;
  logic signed [W-1:0]   dac_d;
  logic signed [W-1:0]   dac_q;

  always_comb begin
    km      = $signed({1'b0, idx_i}) * msg_i;
    env_sum = ONE_S + SW'(km >>> (W - 1));
    if (!en_i) begin
      env_d = ONE_U;
    end else if (env_sum < 0) begin
      env_d = '0;
    end else if (env_sum > ENV_MAX) begin
      env_d = '1;
    end else begin
      env_d = IW'(env_sum);
    end
    prod  = car_i * $signed({1'b0, env_q});
    dac_d = W'(prod >>> F);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      env_q <= '0;
      dac_q <= '0;
    end else begin
      env_q <= env_d;
      dac_q <= dac_d;
    end
  end

  assign env_o = env_q;
  assign dac_o = dac_q;

endmodule

// File: rtl/am_interp_mod.sv
module am_interp_mod
  import am_pkg::*;
#(
  parameter int                        SAMPLE_W = 16,
  parameter int                        IDX_W    = 16,
  parameter logic [NUM_STAGES*8-1:0]   FACTORS  = {8'd8, 8'd8, 8'd8, 8'd10},
  parameter int                        TAPS     = 4,
  parameter int                        PHASE_W  = 32,
  parameter logic [PHASE_W-1:0]        TUNE     = 32'd34359738,
  parameter int                        LUT_AW   = 6,
  parameter int                        CAR_AMP  = 16383
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] audio_i,
  input  logic                       audio_vld_i,
  input  logic [IDX_W-1:0]           mod_idx_i,
  input  logic                       en_i,
  output logic signed [SAMPLE_W-1:0] dac_o
);

  localparam int NUM      = NUM_STAGES;
  localparam int TICK_GAP = rate_span(64'(FACTORS), NUM);

  logic                       rst_meta_q;
  logic                       rst_q;
  logic signed [SAMPLE_W-1:0] audio_q;
  logic signed [SAMPLE_W-1:0] audio_d;
  logic [NUM-1:0]             tick;
  logic signed [SAMPLE_W-1:0] chain [NUM+1];
  logic signed [SAMPLE_W-1:0] car_w;
  logic [IDX_W-1:0]           env_w;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  always_comb begin
    audio_d = audio_vld_i ? audio_i : audio_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      audio_q <= '0;
    end else begin
      audio_q <= audio_d;
    end
  end

  am_rate_timebase #(
    .NUM     (NUM),
    .FACTORS (FACTORS)
  ) timebase_i (
    .clk    (clk),
    .rst_n  (rst_q),
    .tick_o (tick)
  );

  assign chain[0] = audio_q;

  for (genvar s = 0; s < NUM; s++) begin : g_stage
    am_interp_stage #(
      .W    (SAMPLE_W),
      .TAPS (TAPS)
    ) stage_i (
      .clk    (clk),
      .rst_n  (rst_q),
      .tick_i (tick[s]),
      .din    (chain[s]),
      .dout   (chain[s+1])
    );
  end

  am_dds #(
    .PHASE_W (PHASE_W),
    .TUNE    (TUNE),
    .AW      (LUT_AW),
    .W       (SAMPLE_W),
    .AMP     (CAR_AMP)
  ) dds_i (
    .clk   (clk),
    .rst_n (rst_q),
    .car_o (car_w)
  );

  am_modulator #(
    .W  (SAMPLE_W),
    .IW (IDX_W)
  ) mod_i (
    .clk   (clk),
    .rst_n (rst_q),
    .msg_i (chain[NUM]),
    .idx_i (mod_idx_i),
    .en_i  (en_i),
    .car_i (car_w),
    .env_o (env_w),
    .dac_o (dac_o)
  );

endmodule

// File: rtl/am_interp_mod_chk.sv
module am_interp_mod_chk #(
  parameter int W        = 16,
  parameter int IW       = 16,
  parameter int CAR_AMP  = 16383,
  parameter int TICK_GAP = 512
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en_i,
  input logic                audio_vld_i,
  input logic signed [W-1:0] audio_q,
  input logic                first_tick,
  input logic [IW-1:0]       env_q,
  input logic signed [W-1:0] dac_o
);

  logic [31:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (first_tick) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + 32'd1;
    end
  end

  // R2: the captured sample moves only on a strobe
  assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !audio_vld_i |=> $stable(audio_q));

  // R5: enable low two edges earlier gives the bare carrier
  assert_carrier_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i, 2) |-> (dac_o <= CAR_AMP && dac_o >= -CAR_AMP));

  // R6: clamped envelope bounds the output peak
  assert_out_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_o <= 2 * CAR_AMP && dac_o >= -2 * CAR_AMP));

  // R7: zero envelope silences the next output
  assert_zero_env_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (env_q == '0) |=> (dac_o == '0));

  // R8: first stage updates at a fixed spacing
  assert_tick_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    first_tick |-> (gap_q == 32'(TICK_GAP - 1)));

endmodule

bind am_interp_mod am_interp_mod_chk #(
  .W        (SAMPLE_W),
  .IW       (IDX_W),
  .CAR_AMP  (CAR_AMP),
  .TICK_GAP (TICK_GAP)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_q),
  .en_i        (en_i),
  .audio_vld_i (audio_vld_i),
  .audio_q     (audio_q),
  .first_tick  (tick[0]),
  .env_q       (env_w),
  .dac_o       (dac_o)
);

// File: tb/am_interp_mod_tb_top.sv
module am_interp_mod_tb_top;

  localparam int AMP    = 16383;
  localparam int SETTLE = 2400;
  localparam int NVEC   = 8;
  // Fields: {enable, index k (unsigned Q1.15), sample m (signed Q0.15)}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 16'h8000, 16'h0000},
    {1'b1, 16'h8000, 16'h4000},
    {1'b1, 16'h4000, 16'hC000},
    {1'b1, 16'h8000, 16'h8000},
    {1'b1, 16'hFFFF, 16'h7FFF},
    {1'b0, 16'hFFFF, 16'h7FFF},
    {1'b1, 16'hFFFF, 16'h8000},
    {1'b1, 16'h0000, 16'h4E20}
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic signed [15:0] audio_i;
  logic               audio_vld_i;
  logic [15:0]        mod_idx_i;
  logic               en_i;
  logic signed [15:0] dac_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  am_interp_mod dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .audio_i     (audio_i),
    .audio_vld_i (audio_vld_i),
    .mod_idx_i   (mod_idx_i),
    .en_i        (en_i),
    .dac_o       (dac_o)
  );

  function automatic string vec_tag(int i);
    case (i)
      1:       return "R9";
      3, 6:    return "R7";
      4:       return "R6";
      5:       return "R5";
      default: return "R3";
    endcase
  endfunction

  // Expected peak from the envelope formula
  function automatic int peak_of(bit en, int k, int m);
    longint e;
    if (!en) begin
      e = 32768;
    end else begin
      e = 32768 + ((longint'(k) * longint'(m)) >>> 15);
      if (e < 0) e = 0;
      if (e > 65535) e = 65535;
    end
    return int'((longint'(AMP) * e) >>> 15);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(int m);
    audio_i     = 16'(m);
    audio_vld_i = 1'b1;
    @(negedge clk);
    audio_vld_i = 1'b0;
  endtask

  task automatic measure(int n, output int mx, output int mn, output int xc);
    int prev;
    mx   = -100000;
    mn   = 100000;
    xc   = 0;
    prev = int'(dac_o);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (int'(dac_o) > mx) mx = int'(dac_o);
      if (int'(dac_o) < mn) mn = int'(dac_o);
      if (prev < 0 && int'(dac_o) >= 0) xc++;
      prev = int'(dac_o);
    end
  endtask

  task automatic check_peak(int exp, string req, string what);
    int mx;
    int mn;
    int xc;
    int tol;
    measure(250, mx, mn, xc);
    tol = exp / 128 + 4;
    check((mx - exp) <= tol && (exp - mx) <= tol, req, {what, " peak"}, mx, exp);
    check((mn + exp) <= tol && (-exp - mn) <= tol, req, {what, " trough"}, mn, -exp);
  endtask

  initial begin
    int mx;
    int mn;
    int xc;
    rst_n       = 1'b0;
    audio_i     = '0;
    audio_vld_i = 1'b0;
    mod_idx_i   = '0;
    en_i        = 1'b0;
    cycles(5);
    // R1: output quiet in reset
    check(dac_o == 16'sd0, "R1", "dac_o in reset", int'(dac_o), 0);
    rst_n = 1'b1;
    cycles(4);

    // R4: carrier frequency with modulation off
    measure(12500, mx, mn, xc);
    check(xc >= 99 && xc <= 101, "R4", "rising crossings", xc, 100);

    // Table walk: R3 R5 R6 R7 R9, each settled for SETTLE clocks
    for (int i = 0; i < NVEC; i++) begin
      en_i      = VEC[i][32];
      mod_idx_i = VEC[i][31:16];
      strobe(int'($signed(VEC[i][15:0])));
      cycles(SETTLE);
      check_peak(peak_of(VEC[i][32], int'(VEC[i][31:16]), int'($signed(VEC[i][15:0]))),
                 vec_tag(i), $sformatf("vector %0d", i));
    end

    // R1: reset in mid-operation clears the output at once
    en_i      = 1'b0;
    mod_idx_i = 16'h8000;
    cycles(10);
    rst_n = 1'b0;
    #1;
    check(dac_o == 16'sd0, "R1", "dac_o after mid-run reset", int'(dac_o), 0);
    cycles(3);
    rst_n = 1'b1;
    cycles(4);

    // R2: a new sample without the strobe is ignored, then taken with it
    en_i = 1'b1;
    strobe(0);
    cycles(SETTLE);
    audio_i = 16'sd30000;
    cycles(SETTLE);
    check_peak(peak_of(1'b1, 32768, 0), "R2", "no-strobe change");
    strobe(30000);
    cycles(SETTLE);
    check_peak(peak_of(1'b1, 32768, 30000), "R2", "strobed change");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=150000 expected<150000");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule